// File: doc/BRIEF.md
# Majority-Clocked Triple LFSR Keystream Generator

This block produces a 64-bit keystream word from three linear feedback shift registers of 19, 22 and 23 bits. A parallel load sets all three register states at once. A start request then runs the generator, which emits one output bit per clock cycle and shifts it into a result register. When the word is complete, a one-cycle done pulse is raised.

The clocking is irregular. On every step, each register offers one clock-control bit, and the three bits are put to a majority vote. Only the registers whose control bit agrees with the vote shift, so at least two of the three advance on every step. The first output bit comes from the loaded state before any step is taken, so a full 64-bit word needs 63 steps.

Top module: `mclk_keystream_gen`

## Requirements
- R1: After reset, `busy`, `done` and `result` are all zero, and all three registers are zero.
- R2: When a register steps, it shifts left by one and drops the bit above its width. Bit 0 receives the XOR of its taps. The taps are {18,17,16,13} for the 19-bit register A, {21,20} for the 22-bit register B, and {22,21,20,7} for the 23-bit register C.
- R3: The control bits are A[8], B[10] and C[10]. The majority is 1 when at least two of them are 1. A register steps only when its own control bit equals the majority, and otherwise it holds. Feedback and majority are computed from the register contents before the step.
- R4: Each output bit is A[18] XOR B[21] XOR C[22].
- R5: The first output bit is taken from the state present when start is accepted, and each of the 63 steps adds one bit. Bits enter `result` at bit 0 and move left, so the first bit ends at bit 63.
- R6: If start is accepted at clock edge E0, `busy` is 1 after edges E0 through E62. After edge E63, `busy` is 0, `done` is 1 and `result` holds the full word. `done` is 1 for exactly one cycle.
- R7: `load` and `start` are ignored while `busy` is 1. The registers and the run length are unaffected.
- R8: While `busy` is 0, `result` holds its value until a start is accepted.
- R9: When `load` and `start` are asserted together while idle, the load takes effect and the start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load | input | 1 | Parallel load strobe for the three registers |
| seed_a | input | 19 | Load value for register A |
| seed_b | input | 22 | Load value for register B |
| seed_c | input | 23 | Load value for register C |
| start | input | 1 | Begins generation of one 64-bit word |
| busy | output | 1 | High while the steps are in progress |
| done | output | 1 | One-cycle pulse when the word is complete |
| result | output | 64 | Keystream word, first bit in the MSB |

## Verification
The assertions assume that `load` and `start` are clean, single-edge-sampled levels. They also assume that the control logic is the only thing that decides whether a register moves, so when no step enable is present the state must hold. The bench drives all inputs on the falling edge, so every strobe is stable at the rising edge where it is sampled. It keeps `load` and `start` as one-cycle pulses, except in the deliberate cases where they are asserted during a run, or together, to exercise R7 and R9.

// File: rtl/kg_pkg.sv
package kg_pkg;
  localparam int          LEN_A     = 19;
  localparam int          LEN_B     = 22;
  localparam int          LEN_C     = 23;
  localparam logic [31:0] TAP_A     = 32'h0007_2000;  // 18,17,16,13
  localparam logic [31:0] TAP_B     = 32'h0030_0000;  // 21,20
  localparam logic [31:0] TAP_C     = 32'h0070_0080;  // 22,21,20,7
  localparam int          CTL_A     = 8;
  localparam int          CTL_B     = 10;
  localparam int          CTL_C     = 10;
  localparam int          WORD_BITS = 64;
endpackage

// File: rtl/kg_lfsr_stage.sv
module kg_lfsr_stage #(
  parameter int          W    = 19,
  parameter logic [31:0] TAPS = 32'h0007_2000,
  parameter int          CBIT = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_en,
  input  logic         step_en,
  input  logic [W-1:0] ld_val,
  output logic [W-1:0] q,
  output logic         ctl_bit,
  output logic         nxt_top
);
  logic [W-1:0] q_nxt;
  logic         fb;

  always_comb fb = ^(q & TAPS[W-1:0]);

  always_comb begin
    q_nxt = q;
    if (ld_en)        q_nxt = ld_val;
    else if (step_en) q_nxt = {q[W-2:0], fb};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign ctl_bit = q[CBIT];
  assign nxt_top = q_nxt[W-1];

  assert_hold_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && !step_en) |=> $stable(q));

  assert_shift_left_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !ld_en) |=> (q[W-1:1] == $past(q[W-2:0])));
endmodule

// File: rtl/kg_vote.sv
module kg_vote (
  input  logic a,
  input  logic b,
  input  logic c,
  output logic maj
);
  always_comb maj = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/kg_seq.sv
module kg_seq #(
  parameter int WORD = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            go,
  input  logic            bit_now,
  input  logic            bit_next,
  output logic            busy,
  output logic            done,
  output logic [WORD-1:0] result
);
  localparam int          STEPS = WORD - 1;
  localparam int          CW    = $clog2(STEPS);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  logic [CW-1:0]   cnt, cnt_n;
  logic            busy_n, done_n;
  logic [WORD-1:0] res_n;

  always_comb begin
    busy_n = busy;
    done_n = 1'b0;
    cnt_n  = cnt;
    res_n  = result;
    if (go) begin
      busy_n = 1'b1;
      cnt_n  = '0;
      res_n  = {{(WORD-1){1'b0}}, bit_now};
    end else if (busy) begin
      res_n = {result[WORD-2:0], bit_next};
      cnt_n = cnt + 1'b1;
      if (cnt == LAST) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cnt    <= '0;
      result <= '0;
    end else begin
      busy   <= busy_n;
      done   <= done_n;
      cnt    <= cnt_n;
      result <= res_n;
    end
  end

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_on_finish_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go) |=> $stable(result));
endmodule

// File: rtl/mclk_keystream_gen.sv
module mclk_keystream_gen
  import kg_pkg::*;
#(
  parameter int WORD = WORD_BITS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [LEN_A-1:0] seed_a,
  input  logic [LEN_B-1:0] seed_b,
  input  logic [LEN_C-1:0] seed_c,
  input  logic            start,
  output logic            busy,
  output logic            done,
  output logic [WORD-1:0] result
);
  logic [LEN_A-1:0] qa;
  logic [LEN_B-1:0] qb;
  logic [LEN_C-1:0] qc;
  logic ca, cb, cc, maj;
  logic sa, sb, sc;
  logic na, nb, nc;
  logic ld_en, go, bit_now, bit_next;

  always_comb begin
    ld_en    = load & ~busy;
    go       = start & ~load & ~busy;
    sa       = busy & (ca == maj);
    sb       = busy & (cb == maj);
    sc       = busy & (cc == maj);
    bit_now  = qa[LEN_A-1] ^ qb[LEN_B-1] ^ qc[LEN_C-1];
    bit_next = na ^ nb ^ nc;
  end

  kg_vote u_vote (.a(ca), .b(cb), .c(cc), .maj(maj));

  kg_lfsr_stage #(.W(LEN_A), .TAPS(TAP_A), .CBIT(CTL_A)) u_reg_a (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .step_en(sa), .ld_val(seed_a),
    .q(qa), .ctl_bit(ca), .nxt_top(na));

  kg_lfsr_stage #(.W(LEN_B), .TAPS(TAP_B), .CBIT(CTL_B)) u_reg_b (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .step_en(sb), .ld_val(seed_b),
    .q(qb), .ctl_bit(cb), .nxt_top(nb));

  kg_lfsr_stage #(.W(LEN_C), .TAPS(TAP_C), .CBIT(CTL_C)) u_reg_c (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .step_en(sc), .ld_val(seed_c),
    .q(qc), .ctl_bit(cc), .nxt_top(nc));

  kg_seq #(.WORD(WORD)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(go), .bit_now(bit_now), .bit_next(bit_next),
    .busy(busy), .done(done), .result(result));

  assert_two_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ($countones({sa, sb, sc}) >= 2));

  assert_busy_blocks_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && load && !sa) |=> $stable(qa));
endmodule

// File: tb/tb_mclk_keystream_gen.sv
`timescale 1ns/1ps
module tb_mclk_keystream_gen;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load, start;
  logic [18:0] seed_a;
  logic [21:0] seed_b;
  logic [22:0] seed_c;
  logic        busy, done;
  logic [63:0] result;

  int n_chk = 0;
  int n_fail = 0;

  logic [18:0] cur_a;
  logic [21:0] cur_b;
  logic [22:0] cur_c;

  always #2.5 clk = ~clk;

  mclk_keystream_gen dut (
    .clk(clk), .rst_n(rst_n), .load(load), .seed_a(seed_a), .seed_b(seed_b),
    .seed_c(seed_c), .start(start), .busy(busy), .done(done), .result(result));

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Behavioural model: fills the word from the MSB downward.
  task automatic model(inout logic [18:0] a, inout logic [21:0] b,
                       inout logic [22:0] c, output logic [63:0] w);
    int votes;
    bit m, fa, fb, fc;
    w = '0;
    w[63] = a[18] ^ b[21] ^ c[22];
    for (int s = 1; s < 64; s++) begin
      votes = int'(a[8]) + int'(b[10]) + int'(c[10]);
      m  = (votes >= 2);
      fa = a[18] ^ a[17] ^ a[16] ^ a[13];
      fb = b[21] ^ b[20];
      fc = c[22] ^ c[21] ^ c[20] ^ c[7];
      if (a[8] == m)  a = {a[17:0], fa};
      if (b[10] == m) b = {b[20:0], fb};
      if (c[10] == m) c = {c[21:0], fc};
      w[63-s] = a[18] ^ b[21] ^ c[22];
    end
  endtask

  task automatic do_load(input logic [18:0] a, input logic [21:0] b,
                         input logic [22:0] c);
    @(negedge clk);
    load = 1'b1; seed_a = a; seed_b = b; seed_c = c;
    @(negedge clk);
    load = 1'b0;
    cur_a = a; cur_b = b; cur_c = c;
  endtask

  task automatic run(input bit disturb, input string req);
    logic [63:0] exp;
    int bad;
    model(cur_a, cur_b, cur_c, exp);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bad = 0;
    for (int k = 0; k < 63; k++) begin
      if (k > 0) @(negedge clk);
      if (!busy || done) bad++;
      if (disturb && k == 20) begin
        load = 1'b1; start = 1'b1;
        seed_a = 19'h5A5A5; seed_b = 22'h3C3C3C; seed_c = 23'h7E7E7E;
      end else begin
        load = 1'b0; start = 1'b0;
      end
    end
    chk(bad == 0, "R6 busy window", 64'(bad), 64'd0);
    @(negedge clk);
    chk(!busy && done, "R6 finish flags", {62'd0, busy, done}, 64'd1);
    chk(result == exp, req, result, exp);
    chk(result[63] == (exp[63]), "R4 first bit", 64'(result[63]), 64'(exp[63]));
    @(negedge clk);
    chk(!done, "R6 done single cycle", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    chk(result == exp, "R8 result held", result, exp);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    logic [63:0] snap;
    rst_n = 1'b0; load = 1'b0; start = 1'b0;
    seed_a = '0; seed_b = '0; seed_c = '0;
    cur_a = '0; cur_b = '0; cur_c = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == 0, "R1 reset outputs", result, 64'd0);
    rst_n = 1'b1;
    run(1'b0, "R1 zero state word");

    do_load(19'h7FFFF, 22'h3FFFFF, 23'h7FFFFF);
    run(1'b0, "R3 all ones word");
    do_load(19'h40000, 22'h0, 23'h0);
    run(1'b0, "R4 single top bit word");
    do_load(19'h00100, 22'h000400, 23'h0);
    run(1'b0, "R3 control bits word");
    do_load(19'h02000, 22'h100000, 23'h000080);
    run(1'b0, "R2 tap bits word");
    run(1'b0, "R5 continue from state");

    for (int i = 0; i < 12; i++) begin
      do_load(19'($urandom), 22'($urandom), 23'($urandom));
      run(1'b0, "R5 random word");
    end

    // R7: load and start during a run are ignored.
    do_load(19'h1234, 22'h2BCDE, 23'h3F0F0);
    run(1'b1, "R7 disturbed run word");
    run(1'b0, "R7 state untouched by busy load");

    // R9: load with start at the same time.
    @(negedge clk);
    load = 1'b1; start = 1'b1;
    seed_a = 19'h0ABCD; seed_b = 22'h15555; seed_c = 23'h2AAAA;
    @(negedge clk);
    load = 1'b0; start = 1'b0;
    cur_a = 19'h0ABCD; cur_b = 22'h15555; cur_c = 23'h2AAAA;
    chk(!busy, "R9 start ignored with load", 64'(busy), 64'd0);
    snap = result;
    @(negedge clk);
    chk(result == snap, "R8 result idle", result, snap);
    run(1'b0, "R9 loaded state word");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule